// File: doc/BRIEF.md
# Closest PLL Setting Search Engine

This block takes a reference frequency and a requested output frequency in hertz and picks, from a fixed table of PLL settings, the entry whose output lands nearest the request. Each table entry has a multiplier, a power-of-two divisor, an inclusive window of reference rates where the entry may be used, and the input-divider, feedback, output-divider and post-divider codes that a clock controller would program. A pulse on `start` captures both frequencies. The block then checks one table entry per clock, beginning at the highest index and ending at index 0.

When the scan ends, `done` pulses for one cycle. At the same time the block presents whether a usable entry exists, the winning index and that entry's codes. When no entry accepts the reference, `found` is low and the index reads as all ones, which is the two's-complement value -1 at the index width. Results stay on the outputs until the next search finishes. Divisors are stored as shift amounts, so candidates are computed with no divider.

Top module: `pll_search`

## Requirements
- R1: After synchronous reset, done=0, found=0, index is all ones, the four code outputs are 0 and post_div_on is 0.
- R2: An entry takes part only when its low bound <= captured reference <= its high bound. Both bounds count as inside.
- R3: An entry's candidate frequency is floor(reference * multiplier / divisor), with the divisor 2^shift.
- R4: The reported entry has the smallest |candidate - target| among the entries that take part.
- R5: Entries are evaluated from index N-1 down to 0. A later entry replaces the kept one only when its difference is strictly smaller, so on a tie the higher index wins.
- R6: When no entry takes part, found=0, index is all ones (-1) and all code outputs are 0.
- R7: done is a single-cycle pulse on the (N+1)th rising edge after the edge that samples start. found and index change only on that edge.
- R8: start while a scan is running is ignored. The reference and target are captured on the accepted start edge, and later changes to them do not affect that search.
- R9: When found=1, cfg_r, cfg_f, cfg_q and cfg_d (two's complement) equal the winning entry's codes. post_div_on is 1 exactly when that entry's D code is >= 0, and 0 when it is negative (post-divider bypassed).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| ref_hz | input | 32 | Reference frequency in Hz |
| target_hz | input | 32 | Requested frequency in Hz |
| done | output | 1 | One-cycle pulse when a result is ready |
| found | output | 1 | A usable entry exists |
| index | output | IDX_W+1 | Winning entry index, all ones when none |
| cfg_r | output | 3 | Input divider code of the winner |
| cfg_f | output | 6 | Feedback code of the winner |
| cfg_q | output | 2 | Output divider code of the winner |
| cfg_d | output | 7 | Post-divider code of the winner, signed |
| post_div_on | output | 1 | Winner uses the post-divider |

## Verification
All results of a search are due together, N+1 rising edges after the start edge, and are registered. The bench counts falling edges from the start edge and expects done at count N+2, then reads every output on that same falling edge. It also checks that done is low on the next falling edge. The bench drives a start pulse and changes the operands partway through a scan to confirm that the timing and the result do not change.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;
  localparam int FREQ_W = 32;
  localparam int MUL_W  = 6;
  localparam int SHF_W  = 3;
  localparam int R_W    = 3;
  localparam int F_W    = 6;
  localparam int Q_W    = 2;
  localparam int D_W    = 7;

  typedef struct packed {
    logic [MUL_W-1:0]  mul;
    logic [SHF_W-1:0]  shf;
    logic [FREQ_W-1:0] lo;
    logic [FREQ_W-1:0] hi;
    logic [R_W-1:0]    r;
    logic [F_W-1:0]    f;
    logic [Q_W-1:0]    q;
    logic [D_W-1:0]    d;
  } entry_t;

  function automatic entry_t mk(int mul, int shf, int lo, int hi,
                                int r, int f, int q, int d);
    entry_t e;
    e.mul = MUL_W'(mul);
    e.shf = SHF_W'(shf);
    e.lo  = FREQ_W'(lo);
    e.hi  = FREQ_W'(hi);
    e.r   = R_W'(r);
    e.f   = F_W'(f);
    e.q   = Q_W'(q);
    e.d   = D_W'(d);
    return e;
  endfunction

  // Representative settings; unused slots have an empty window.
  function automatic entry_t rom_entry(int i);
    case (i)
      0:  return mk( 1, 5, 12000000, 24000000, 1, 31, 3, 63);
      1:  return mk( 1, 3,  6000000, 12000000, 0, 31, 3, 31);
      2:  return mk( 1, 1, 12000000, 24000000, 1, 31, 1, 15);
      3:  return mk( 2, 0,  6000000, 12000000, 0, 31, 1,  7);
      4:  return mk( 2, 0, 12000000, 24000000, 1, 31, 1,  3);
      5:  return mk( 4, 0, 12000000, 24000000, 1, 31, 3, -1);
      6:  return mk( 6, 0, 12000000, 16000000, 1, 47, 3, -1);
      7:  return mk( 8, 0, 12000000, 24000000, 1, 31, 2, -1);
      8:  return mk( 8, 0,  6000000, 12000000, 0, 31, 3, -1);
      9:  return mk(12, 0, 12000000, 16000000, 1, 47, 2, -1);
      10: return mk(16, 0,  6000000, 12000000, 0, 31, 2, -1);
      11: return mk(16, 0, 12000000, 24000000, 1, 31, 1, -1);
      default: return mk(0, 0, 1, 0, 0, 0, 0, 0);
    endcase
  endfunction
endpackage

// File: rtl/pllsrch_rom.sv
module pllsrch_rom
  import pllsrch_pkg::*;
#(
  parameter int N = 12,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output entry_t        q
);
  always_ff @(posedge clk) begin
    if (en) q <= rom_entry(int'(addr));
  end
endmodule

// File: rtl/pllsrch_eval.sv
module pllsrch_eval
  import pllsrch_pkg::*;
#(
  localparam int PROD_W = FREQ_W + MUL_W
) (
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [FREQ_W-1:0] tgt_hz,
  input  entry_t            ent,
  output logic              usable,
  output logic [PROD_W-1:0] diff
);
  logic [PROD_W-1:0] prod, cand, tgt_x;

  assign prod   = {{MUL_W{1'b0}}, ref_hz} * {{FREQ_W{1'b0}}, ent.mul};
  assign cand   = prod >> ent.shf;
  assign tgt_x  = {{MUL_W{1'b0}}, tgt_hz};
  assign usable = (ref_hz >= ent.lo) && (ref_hz <= ent.hi);
  assign diff   = (cand >= tgt_x) ? (cand - tgt_x) : (tgt_x - cand);
endmodule

// File: rtl/pll_search.sv
module pll_search
  import pllsrch_pkg::*;
#(
  parameter int N = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       ref_hz,
  input  logic [31:0]       target_hz,
  output logic              done,
  output logic              found,
  output logic [IDX_W:0]    index,
  output logic [2:0]        cfg_r,
  output logic [5:0]        cfg_f,
  output logic [1:0]        cfg_q,
  output logic [6:0]        cfg_d,
  output logic              post_div_on
);
  localparam int PROD_W = FREQ_W + MUL_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic              busy, issuing, ev_vld;
  logic [IDX_W-1:0]  rd_idx, ev_idx;
  logic [FREQ_W-1:0] ref_q, tgt_q;
  entry_t            rom_q;
  logic              cand_ok;
  logic [PROD_W-1:0] cand_diff;

  logic [PROD_W-1:0] best_diff, nxt_diff;
  logic              best_hit, nxt_hit, take;
  logic [IDX_W-1:0]  best_idx, nxt_idx;
  entry_t            best_ent, nxt_ent;

  pllsrch_rom #(.N(N)) u_rom (
    .clk(clk), .en(issuing), .addr(rd_idx), .q(rom_q)
  );

  pllsrch_eval u_eval (
    .ref_hz(ref_q), .tgt_hz(tgt_q), .ent(rom_q),
    .usable(cand_ok), .diff(cand_diff)
  );

  always_comb begin
    take     = ev_vld && cand_ok && (cand_diff < best_diff);
    nxt_diff = take ? cand_diff : best_diff;
    nxt_hit  = take | best_hit;
    nxt_idx  = take ? ev_idx : best_idx;
    nxt_ent  = take ? rom_q : best_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      issuing     <= 1'b0;
      ev_vld      <= 1'b0;
      rd_idx      <= '0;
      ev_idx      <= '0;
      ref_q       <= '0;
      tgt_q       <= '0;
      best_diff   <= '1;
      best_hit    <= 1'b0;
      best_idx    <= '0;
      best_ent    <= '0;
      done        <= 1'b0;
      found       <= 1'b0;
      index       <= '1;
      cfg_r       <= '0;
      cfg_f       <= '0;
      cfg_q       <= '0;
      cfg_d       <= '0;
      post_div_on <= 1'b0;
    end else begin
      done   <= 1'b0;
      ev_vld <= issuing;
      ev_idx <= rd_idx;
      if (!busy && start) begin
        busy      <= 1'b1;
        issuing   <= 1'b1;
        rd_idx    <= LAST;
        ref_q     <= ref_hz;
        tgt_q     <= target_hz;
        best_diff <= '1;
        best_hit  <= 1'b0;
        best_idx  <= '0;
        best_ent  <= '0;
      end else if (issuing) begin
        if (rd_idx == '0) issuing <= 1'b0;
        else              rd_idx  <= rd_idx - 1'b1;
      end
      if (ev_vld) begin
        best_diff <= nxt_diff;
        best_hit  <= nxt_hit;
        best_idx  <= nxt_idx;
        best_ent  <= nxt_ent;
        if (ev_idx == '0) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          found       <= nxt_hit;
          index       <= nxt_hit ? {1'b0, nxt_idx} : '1;
          cfg_r       <= nxt_hit ? nxt_ent.r : '0;
          cfg_f       <= nxt_hit ? nxt_ent.f : '0;
          cfg_q       <= nxt_hit ? nxt_ent.q : '0;
          cfg_d       <= nxt_hit ? nxt_ent.d : '0;
          post_div_on <= nxt_hit && !nxt_ent.d[D_W-1];
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  miss_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (index == '1 && cfg_d == '0));

  // R8
  hold_ops_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ref_q) && $stable(tgt_q)));

  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (best_diff <= $past(best_diff)));

  // R9
  postdiv_chk: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (post_div_on != cfg_d[D_W-1]));

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (index < (IDX_W+1)'(N)));
endmodule

// File: tb/pll_search_test.sv
module pll_search_test;
  import pllsrch_pkg::*;
  localparam int N = 12;
  localparam int IDX_W = $clog2(N);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] ref_hz = '0, target_hz = '0;
  logic done, found, post_div_on;
  logic [IDX_W:0] index;
  logic [2:0] cfg_r;
  logic [5:0] cfg_f;
  logic [1:0] cfg_q;
  logic [6:0] cfg_d;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pll_search #(.N(N)) uut (
    .clk(clk), .rst(rst), .start(start), .ref_hz(ref_hz), .target_hz(target_hz),
    .done(done), .found(found), .index(index), .cfg_r(cfg_r), .cfg_f(cfg_f),
    .cfg_q(cfg_q), .cfg_d(cfg_d), .post_div_on(post_div_on)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(longint rf, longint tg, output int bi);
    longint best = 64'h7fff_ffff_ffff_ffff;
    bi = -1;
    for (int i = N - 1; i >= 0; i--) begin
      entry_t e = rom_entry(i);
      if (rf >= longint'(e.lo) && rf <= longint'(e.hi)) begin
        longint c = (rf * longint'(e.mul)) / (longint'(1) << e.shf);
        longint d = (c > tg) ? c - tg : tg - c;
        if (d < best) begin
          best = d;
          bi = i;
        end
      end
    end
  endfunction

  // Runs one search; when disturb is set, a start pulse with other operands
  // is driven in the middle of the scan (R8).
  task automatic run(longint rf, longint tg, bit disturb, string tag);
    int bi, cyc;
    entry_t e;
    model(rf, tg, bi);
    @(negedge clk);
    ref_hz = 32'(rf); target_hz = 32'(tg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (disturb && cyc == 3) begin
        start = 1'b1; ref_hz = 32'd12000000; target_hz = 32'd192000000;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == N + 2, "R7", {tag, " done latency"}, cyc, N + 2);
    if (bi < 0) begin
      check(!found && index == '1, "R6", {tag, " miss index"}, longint'(index), (1 << (IDX_W + 1)) - 1);
      check(cfg_d == 0 && cfg_f == 0 && !post_div_on, "R6", {tag, " miss codes"}, longint'(cfg_f), 0);
    end else begin
      e = rom_entry(bi);
      check(found && index == (IDX_W+1)'(bi), "R4", {tag, " index"}, found ? longint'(index) : -1, bi);
      check(cfg_r == e.r && cfg_f == e.f && cfg_q == e.q && cfg_d == e.d, "R9",
            {tag, " codes"}, longint'({cfg_r, cfg_f, cfg_q, cfg_d}), longint'({e.r, e.f, e.q, e.d}));
      check(post_div_on == !e.d[6], "R9", {tag, " post divider"}, post_div_on, !e.d[6]);
    end
    @(negedge clk);
    check(!done, "R7", {tag, " single pulse"}, done, 0);
    if (disturb) begin
      repeat (N + 3) begin
        @(negedge clk);
        check(!done, "R8", {tag, " no second result"}, done, 0);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(0, "R7", "watchdog expired", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !found && index == '1 && cfg_r == 0 && cfg_f == 0 && cfg_q == 0
          && cfg_d == 0 && !post_div_on, "R1", "reset state", longint'(index), (1 << (IDX_W + 1)) - 1);
    // R5 tie between 7 and 8 at 12 MHz (also R2 shared bound): 8 wins
    run(12000000, 96000000, 0, "R5 tie 7/8");
    // R5 tie between 10 and 11: 11 wins
    run(12000000, 192000000, 0, "R5 tie 10/11");
    // R2 lower bound inclusive
    run(6000000, 96000000, 0, "R2 low bound");
    // R2 just below every window, R6
    run(5999999, 96000000, 0, "R2 below");
    // R6 above every window
    run(50000000, 100000000, 0, "R6 above");
    // R3 truncation: 12000001/32 -> 375000 exactly
    run(12000001, 375000, 0, "R3 trunc");
    // R9 negative D code
    run(12000000, 72000000, 0, "R9 neg d");
    // R8 start and operands changed mid-scan
    run(20000000, 160000000, 1, "R8 ignore");
    for (int k = 0; k < 40; k++) begin
      longint rf = 4000000 + longint'($urandom % 28000000);
      longint tg = longint'($urandom % 400000000);
      run(rf, tg, 0, "R4 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule